// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block watches the command stream that a memory controller sends to a four-bank double-data-rate SDRAM and keeps a copy of each bank's state. Every clock it takes one command code, a bank address and an auto-precharge flag. It moves the addressed bank, or all banks for a precharge-all, through its states. It does this with one down-counter per bank that is loaded from programmable timing values given in clock cycles. Downstream checking logic reads the per-bank state vector to decide whether the next command it sees is legal.

Reads and writes that carry auto precharge have two phases. The first is an access phase that cannot be interrupted. It ends exactly where the earliest explicit PRECHARGE would have been allowed. For a read this is half the burst length after the command. For a write it is after the write latency, the data beats and the write recovery time. A precharge phase of tRP cycles follows, and then the bank is idle again. The block checks no addresses, columns or data, and it has no refresh or power-down handling.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After a synchronous active-low reset every bank reports IDLE (code 0) and all timing counters are cleared.
- R2: ACTIVE (cmd code 1) to an IDLE bank puts it in ACTIVATING (code 1) for max(tRCD,1) cycles, then in ACTIVE (code 2). A tRCD of zero is treated as one.
- R3: A READ (cmd 2) with the ap flag low, sent to a bank in ACTIVE, READ or WRITE, gives READ (code 3) for CL + BL/2 cycles, then ACTIVE. A WRITE (cmd 3) with the ap flag low gives WRITE (code 4) for 1 + BL/2 cycles, then ACTIVE. The burst select field gives BL = 2, 4, 8, 8 for codes 0, 1, 2, 3.
- R4: A READ with the ap flag high gives RDAP_ACCESS (code 5) for BL/2 cycles, then PRECHARGING (code 7) for max(tRP,1) cycles, then IDLE.
- R5: A WRITE with the ap flag high gives WRAP_ACCESS (code 6) for 1 + BL/2 + tWR cycles, then PRECHARGING for max(tRP,1) cycles, then IDLE.
- R6: PRECHARGE (cmd 4) takes the addressed bank from ACTIVE, READ or WRITE into PRECHARGING for max(tRP,1) cycles, then IDLE. With the ap flag high it acts on every bank that is in one of those states.
- R7: BURST TERMINATE (cmd 5) returns the addressed bank to ACTIVE on the next cycle when that bank is in READ or WRITE. It has no effect on any other bank, and none on a bank in an auto-precharge access phase.
- R8: A command that is not allowed in a bank's state leaves that bank's state and timing unchanged. This covers ACTIVE to a non-idle bank, READ or WRITE to IDLE, any command to ACTIVATING, PRECHARGING or an auto-precharge phase, and the unused codes 6 and 7.
- R9: A READ or WRITE to a bank that is already in READ or WRITE restarts its burst with the full duration of the new command.
- R10: A command addressed to one bank changes no other bank's state, except PRECHARGE with the ap flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are registered on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_code | input | 3 | Command: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 BURST TERMINATE |
| cmd_bank | input | BAW (2) | Bank address of the command |
| cmd_ap | input | 1 | Auto precharge for READ/WRITE; all banks for PRECHARGE |
| t_rcd | input | TW (4) | Activate-to-access delay in cycles |
| t_rp | input | TW (4) | Precharge duration in cycles |
| t_wr | input | TW (4) | Write recovery in cycles |
| burst_sel | input | 2 | Burst length code (0:2, 1:4, 2:8, 3:8) |
| cas_lat | input | CLW (2) | Read latency in whole cycles |
| bank_state | output | NUM_BANKS*3 (12) | State code of bank b in bits [3b+2:3b] |

## Verification
The bench builds the block with its defaults: four banks, 4-bit timing fields and a 2-bit read latency. This keeps the longest phase, a write with auto precharge at BL 8 and tWR 15, within a 6-bit counter that stays small. The timing values change at run time across zero (the clamp to one), small values and every burst code. This brings overlapping bursts, restarts and precharge-all across banks in mixed phases within reach of a few thousand random commands. Directed sequences pin the exact cycle at which each phase ends.

// File: rtl/sbt_pkg.sv
// Package: shared codes and types of the SDRAM bank state tracker.
// Assumes: 3-bit command and state codes, fixed across all instances.
package sbt_pkg;

    typedef enum logic [2:0] {
        BS_IDLE        = 3'd0,
        BS_ACTIVATING  = 3'd1,
        BS_ACTIVE      = 3'd2,
        BS_READ        = 3'd3,
        BS_WRITE       = 3'd4,
        BS_RDAP_ACCESS = 3'd5,
        BS_WRAP_ACCESS = 3'd6,
        BS_PRECHARGING = 3'd7
    } bank_state_e;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5
    } cmd_e;

    // Decoded command, one flag per kind, shared by all banks.
    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic pre_all;
        logic bst;
        logic ap;
    } cmd_dec_t;

endpackage

// File: rtl/sbt_timing_calc.sv
// Module: sbt_timing_calc
// Turns the programmable timing fields into counter load values
// (phase length minus one) for each timed bank phase.
// Assumes: zero tRCD/tRP are clamped to one cycle; burst code 3 means BL 8.
module sbt_timing_calc #(
    parameter int TW  = 4,
    parameter int CLW = 2,
    parameter int CW  = 6
) (
    input  logic [TW-1:0]  t_rcd,
    input  logic [TW-1:0]  t_rp,
    input  logic [TW-1:0]  t_wr,
    input  logic [1:0]     burst_sel,
    input  logic [CLW-1:0] cas_lat,
    output logic [CW-1:0]  ld_rcd,
    output logic [CW-1:0]  ld_rp,
    output logic [CW-1:0]  ld_rd,
    output logic [CW-1:0]  ld_wr,
    output logic [CW-1:0]  ld_rdap,
    output logic [CW-1:0]  ld_wrap
);

    logic [1:0]    half_shift;
    logic [CW-1:0] half_w;
    logic [CW-1:0] cl_w;
    logic [CW-1:0] twr_w;
    logic [CW-1:0] trcd_w;
    logic [CW-1:0] trp_w;

    // Widen the fields and derive the data-beat count BL/2.
    always_comb begin
        half_shift = (burst_sel == 2'd3) ? 2'd2 : burst_sel;
        half_w     = CW'(1) << half_shift;
        cl_w       = CW'(cas_lat);
        twr_w      = CW'(t_wr);
        trcd_w     = CW'(t_rcd);
        trp_w      = CW'(t_rp);
    end

    // Load values: a phase of N cycles loads N-1.
    always_comb begin
        ld_rcd  = (t_rcd == '0) ? '0 : trcd_w - CW'(1);
        ld_rp   = (t_rp == '0) ? '0 : trp_w - CW'(1);
        ld_rd   = cl_w + half_w - CW'(1);
        ld_wr   = half_w;
        ld_rdap = half_w - CW'(1);
        ld_wrap = half_w + twr_w;
    end

    // The precharge boundary of an auto-precharge read never lies after
    // the end of the plain read it is derived from.
    always_comb begin
        if (cas_lat != '0) begin
            // R4
            rdap_before_rd_chk: assert (ld_rdap < ld_rd);
        end
    end

endmodule

// File: rtl/sbt_cmd_decode.sv
// Module: sbt_cmd_decode
// Splits the incoming command into per-kind flags and a one-bit
// address match per bank.
// Assumes: codes 6 and 7 decode to no flag (act as NOP).
module sbt_cmd_decode
    import sbt_pkg::*;
#(
    parameter int NB  = 4,
    parameter int BAW = 2
) (
    input  logic [2:0]     cmd_code,
    input  logic [BAW-1:0] cmd_bank,
    input  logic           cmd_ap,
    output logic [NB-1:0]  bank_hit,
    output cmd_dec_t       dec
);

    // Address compare, one per bank.
    for (genvar g = 0; g < NB; g++) begin : g_hit
        assign bank_hit[g] = (cmd_bank == BAW'(g));
    end

    // Command kind flags.
    always_comb begin
        dec.act     = (cmd_code == CMD_ACT);
        dec.rd      = (cmd_code == CMD_RD);
        dec.wr      = (cmd_code == CMD_WR);
        dec.pre     = (cmd_code == CMD_PRE);
        dec.pre_all = (cmd_code == CMD_PRE) && cmd_ap;
        dec.bst     = (cmd_code == CMD_BST);
        dec.ap      = cmd_ap;
    end

endmodule

// File: rtl/sbt_bank_fsm.sv
// Module: sbt_bank_fsm
// State machine and single down-counter of one bank. Timed phases load
// the counter with their length minus one and leave when it reads zero.
// Assumes: loads are sampled in the cycle the command is registered;
// illegal commands for the current state are silently ignored.
module sbt_bank_fsm
    import sbt_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  cmd_dec_t      dec,
    input  logic [CW-1:0] ld_rcd,
    input  logic [CW-1:0] ld_rp,
    input  logic [CW-1:0] ld_rd,
    input  logic [CW-1:0] ld_wr,
    input  logic [CW-1:0] ld_rdap,
    input  logic [CW-1:0] ld_wrap,
    output logic [2:0]    state_o
);

    bank_state_e   st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          act_me, rd_me, wr_me, pre_me, bst_me;
    logic          cnt_zero;

    // Which command concerns this bank.
    always_comb begin
        act_me   = hit && dec.act;
        rd_me    = hit && dec.rd;
        wr_me    = hit && dec.wr;
        pre_me   = dec.pre && (hit || dec.pre_all);
        bst_me   = hit && dec.bst;
        cnt_zero = (cnt_q == '0);
    end

    // Next state and counter value.
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_zero ? '0 : cnt_q - CW'(1);
        case (st_q)
            BS_IDLE: begin
                if (act_me) begin
                    st_n  = BS_ACTIVATING;
                    cnt_n = ld_rcd;
                end
            end
            BS_ACTIVATING: begin
                if (cnt_zero) st_n = BS_ACTIVE;
            end
            BS_ACTIVE, BS_READ, BS_WRITE: begin
                if (rd_me) begin
                    st_n  = dec.ap ? BS_RDAP_ACCESS : BS_READ;
                    cnt_n = dec.ap ? ld_rdap : ld_rd;
                end else if (wr_me) begin
                    st_n  = dec.ap ? BS_WRAP_ACCESS : BS_WRITE;
                    cnt_n = dec.ap ? ld_wrap : ld_wr;
                end else if (pre_me) begin
                    st_n  = BS_PRECHARGING;
                    cnt_n = ld_rp;
                end else if (bst_me && st_q != BS_ACTIVE) begin
                    st_n  = BS_ACTIVE;
                    cnt_n = '0;
                end else if (st_q != BS_ACTIVE && cnt_zero) begin
                    st_n  = BS_ACTIVE;
                end
            end
            BS_RDAP_ACCESS, BS_WRAP_ACCESS: begin
                if (cnt_zero) begin
                    st_n  = BS_PRECHARGING;
                    cnt_n = ld_rp;
                end
            end
            BS_PRECHARGING: begin
                if (cnt_zero) st_n = BS_IDLE;
            end
            default: begin
                st_n  = BS_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    // State and counter registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign state_o = st_q;

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_IDLE && !act_me) |=> st_q == BS_IDLE);

    // R2
    act_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_ACTIVATING) |=> (st_q == BS_ACTIVATING || st_q == BS_ACTIVE));

    // R4
    rdap_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_RDAP_ACCESS) |=> (st_q == BS_RDAP_ACCESS || st_q == BS_PRECHARGING));

    // R5
    wrap_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_WRAP_ACCESS) |=> (st_q == BS_WRAP_ACCESS || st_q == BS_PRECHARGING));

    // R6
    pre_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_PRECHARGING) |=> (st_q == BS_PRECHARGING || st_q == BS_IDLE));

    // R6
    pre_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_ACTIVE && pre_me) |=> st_q == BS_PRECHARGING);

    // R7
    bst_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == BS_READ || st_q == BS_WRITE) && bst_me) |=> st_q == BS_ACTIVE);

endmodule

// File: rtl/sdram_bank_tracker.sv
// Module: sdram_bank_tracker (top)
// Tracks the state of every bank of a multi-bank DDR SDRAM from the
// command stream: one decoder, one timing calculator and one state
// machine per bank.
// Assumes: one command per cycle; timing fields may change at any time
// and take effect for commands registered from then on.
module sdram_bank_tracker
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TW        = 4,
    parameter int CLW       = 2,
    localparam int BAW      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             cmd_code,
    input  logic [BAW-1:0]         cmd_bank,
    input  logic                   cmd_ap,
    input  logic [TW-1:0]          t_rcd,
    input  logic [TW-1:0]          t_rp,
    input  logic [TW-1:0]          t_wr,
    input  logic [1:0]             burst_sel,
    input  logic [CLW-1:0]         cas_lat,
    output logic [NUM_BANKS*3-1:0] bank_state
);

    localparam int CW = ((TW > CLW) ? TW : CLW) + 2;

    logic [NUM_BANKS-1:0] bank_hit;
    cmd_dec_t             dec;
    logic [CW-1:0]        ld_rcd, ld_rp, ld_rd, ld_wr, ld_rdap, ld_wrap;

    sbt_cmd_decode #(
        .NB  (NUM_BANKS),
        .BAW (BAW)
    ) u_decode (
        .cmd_code (cmd_code),
        .cmd_bank (cmd_bank),
        .cmd_ap   (cmd_ap),
        .bank_hit (bank_hit),
        .dec      (dec)
    );

    sbt_timing_calc #(
        .TW  (TW),
        .CLW (CLW),
        .CW  (CW)
    ) u_timing (
        .t_rcd     (t_rcd),
        .t_rp      (t_rp),
        .t_wr      (t_wr),
        .burst_sel (burst_sel),
        .cas_lat   (cas_lat),
        .ld_rcd    (ld_rcd),
        .ld_rp     (ld_rp),
        .ld_rd     (ld_rd),
        .ld_wr     (ld_wr),
        .ld_rdap   (ld_rdap),
        .ld_wrap   (ld_wrap)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sbt_bank_fsm #(
            .CW (CW)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (bank_hit[b]),
            .dec     (dec),
            .ld_rcd  (ld_rcd),
            .ld_rp   (ld_rp),
            .ld_rd   (ld_rd),
            .ld_wr   (ld_wr),
            .ld_rdap (ld_rdap),
            .ld_wrap (ld_wrap),
            .state_o (bank_state[3*b +: 3])
        );
    end

endmodule

// File: tb/sdram_bank_tracker_tb.sv
`timescale 1ns/1ps
module sdram_bank_tracker_tb;

    localparam int NB = 4;
    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                           C_WR = 3'd3, C_PRE = 3'd4, C_BST = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd_code = C_NOP;
    logic [1:0]    cmd_bank = '0;
    logic          cmd_ap = 1'b0;
    logic [3:0]    t_rcd = 4'd3, t_rp = 4'd3, t_wr = 4'd2;
    logic [1:0]    burst_sel = 2'd1;
    logic [1:0]    cas_lat = 2'd3;
    logic [NB*3-1:0] bank_state;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model: state code and remaining cycles in that state
    int m_st [NB];
    int m_left [NB];

    always #2 clk = ~clk;

    sdram_bank_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_ap(cmd_ap), .t_rcd(t_rcd), .t_rp(t_rp), .t_wr(t_wr),
        .burst_sel(burst_sel), .cas_lat(cas_lat), .bank_state(bank_state)
    );

    function automatic int dut_st(int i);
        return int'(bank_state[3*i +: 3]);
    endfunction

    function automatic int half_bl();
        return (burst_sel == 2'd0) ? 1 : (burst_sel == 2'd1) ? 2 : 4;
    endfunction

    function automatic int clamp1(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic string req_of(int s);
        case (s)
            1: return "R2";
            3, 4: return "R3";
            5: return "R4";
            6: return "R5";
            7: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Advance the model by one registered command.
    task automatic model_step(logic [2:0] c, int b, bit a);
        for (int i = 0; i < NB; i++) begin
            bit hit = (b == i);
            bit pre_me = (c == C_PRE) && (hit || a);
            case (m_st[i])
                0: if (hit && c == C_ACT) begin m_st[i] = 1; m_left[i] = clamp1(int'(t_rcd)); end
                1: if (m_left[i] == 1) m_st[i] = 2; else m_left[i]--;
                2, 3, 4: begin
                    if (hit && c == C_RD) begin
                        m_st[i] = a ? 5 : 3;
                        m_left[i] = a ? half_bl() : int'(cas_lat) + half_bl();
                    end else if (hit && c == C_WR) begin
                        m_st[i] = a ? 6 : 4;
                        m_left[i] = a ? 1 + half_bl() + int'(t_wr) : 1 + half_bl();
                    end else if (pre_me) begin
                        m_st[i] = 7; m_left[i] = clamp1(int'(t_rp));
                    end else if (hit && c == C_BST && m_st[i] != 2) begin
                        m_st[i] = 2;
                    end else if (m_st[i] != 2) begin
                        if (m_left[i] == 1) m_st[i] = 2; else m_left[i]--;
                    end
                end
                5, 6: if (m_left[i] == 1) begin m_st[i] = 7; m_left[i] = clamp1(int'(t_rp)); end
                      else m_left[i]--;
                default: if (m_left[i] == 1) m_st[i] = 0; else m_left[i]--;
            endcase
        end
    endtask

    // Drive one command, let it register, compare every bank to the model.
    task automatic cycle(logic [2:0] c, int b, bit a);
        cmd_code = c;
        cmd_bank = 2'(b);
        cmd_ap = a;
        model_step(c, b, a);
        @(negedge clk);
        for (int i = 0; i < NB; i++)
            chk(req_of(m_st[i]), dut_st(i), m_st[i], $sformatf("model bank%0d", i));
    endtask

    task automatic nops(int n);
        for (int k = 0; k < n; k++) cycle(C_NOP, 0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NB; i++) begin m_st[i] = 0; m_left[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NB; i++) chk("R1", dut_st(i), 0, "reset state");

        // R2: tRCD 3
        cycle(C_ACT, 1, 1'b0);  chk("R2", dut_st(1), 1, "activating");
        nops(2);                chk("R2", dut_st(1), 1, "still activating");
        nops(1);                chk("R2", dut_st(1), 2, "active after tRCD");
        // R8: read to idle bank ignored
        cycle(C_RD, 0, 1'b0);   chk("R8", dut_st(0), 0, "read to idle");
        // R3: CL3 + BL4/2 = 5 cycles
        cycle(C_RD, 1, 1'b0);   nops(4);
        chk("R3", dut_st(1), 3, "read last cycle");
        nops(1);                chk("R3", dut_st(1), 2, "read done");
        // R7 and R10
        cycle(C_WR, 1, 1'b0);   chk("R3", dut_st(1), 4, "write");
        cycle(C_BST, 1, 1'b0);  chk("R7", dut_st(1), 2, "bst ends burst");
        chk("R10", dut_st(0), 0, "other bank unchanged");
        // R9: restart read
        cycle(C_RD, 1, 1'b0);   nops(3);
        cycle(C_RD, 1, 1'b0);   nops(4);
        chk("R9", dut_st(1), 3, "restarted read");
        nops(1);
        // R4 with ignored PRE during access
        cycle(C_RD, 1, 1'b1);   chk("R4", dut_st(1), 5, "rdap access");
        cycle(C_PRE, 1, 1'b0);  chk("R8", dut_st(1), 5, "pre ignored in access");
        nops(1);                chk("R4", dut_st(1), 7, "rdap precharge");
        nops(2);                chk("R4", dut_st(1), 7, "still precharging");
        nops(1);                chk("R4", dut_st(1), 0, "rdap idle");
        // R5: 1 + 2 + tWR 2 = 5 cycles access
        cycle(C_ACT, 3, 1'b0);  nops(3);
        cycle(C_BST, 3, 1'b0);  chk("R7", dut_st(3), 2, "bst on active ignored");
        cycle(C_WR, 3, 1'b1);   nops(4);
        chk("R5", dut_st(3), 6, "wrap access");
        nops(1);                chk("R5", dut_st(3), 7, "wrap precharge");
        nops(3);                chk("R5", dut_st(3), 0, "wrap idle");
        // R6: precharge all
        cycle(C_ACT, 0, 1'b0);  cycle(C_ACT, 2, 1'b0);  nops(3);
        cycle(C_PRE, 1, 1'b1);
        chk("R6", dut_st(0), 7, "pre-all bank0");
        chk("R6", dut_st(2), 7, "pre-all bank2");
        chk("R6", dut_st(1), 0, "pre-all idle bank1");
        nops(2);                chk("R6", dut_st(2), 7, "precharging");
        nops(1);                chk("R6", dut_st(0), 0, "precharge done");
        // R2 clamp of zero timing
        t_rcd = 4'd0;  t_rp = 4'd0;
        cycle(C_ACT, 0, 1'b0);  chk("R2", dut_st(0), 1, "zero tRCD");
        nops(1);                chk("R2", dut_st(0), 2, "zero tRCD clamp");
        cycle(C_PRE, 0, 1'b0);  nops(1);
        chk("R6", dut_st(0), 0, "zero tRP clamp");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [2:0] c;
            if (n % 250 == 0) begin
                t_rcd = 4'($urandom % 7);
                t_rp = 4'($urandom % 7);
                t_wr = 4'($urandom % 16);
                burst_sel = 2'($urandom % 4);
                cas_lat = 2'(1 + $urandom % 3);
            end
            r = int'($urandom % 16);
            c = (r < 3) ? C_NOP : (r < 6) ? C_ACT : (r < 9) ? C_RD :
                (r < 12) ? C_WR : (r < 14) ? C_PRE : (r < 15) ? C_BST : 3'd6;
            cycle(c, int'($urandom % 4), 1'($urandom % 2));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule